// File: doc/BRIEF.md
# Burst Read Latency Controller

This block paces synchronous burst reads from a memory array. A programmable setting fixes how many clock cycles pass between the start of a burst and the first data word. Software changes the setting through a configuration write that carries a 3-bit code. The block then times every burst that follows against that setting. When a burst starts, the block captures the start address. If that address lies on either of the last two words of a 64-word block, the block adds a fixed two-cycle penalty to the wait.

Once the wait has elapsed, the block steps the word address forward by one on every clock. In the wrapping modes the address stays inside an aligned group of 8, 16 or 32 words. In the linear mode it counts on through the whole address space. A ready strobe tells the consumer when data is, or is about to be, present. With the shortest setting the strobe comes up with the first data word. With any longer setting it comes up one cycle early. A new burst start cancels whatever burst is running and begins a fresh wait.

Top module: `burst_lat_ctrl`

## Requirements
- R1: A configuration write with code c in 0..5 sets the initial latency to c+2 cycles. The new setting governs bursts whose start is sampled on a later clock edge. Call the total wait N, where N is the setting plus any penalty. When the start is sampled at edge E0, data word k appears on `word_addr` from edge E(N+k) onward.
- R2: A configuration write carrying code 6 or 7 is ignored, and the previous setting stays in force.
- R3: After reset the setting is 7 cycles, no matter what was written before the reset. During reset and until the first start, `ready` is 0 and `word_addr` is 0.
- R4: If bits [5:0] of the captured start address equal 0x3E or 0x3F, the total wait N is the setting plus 2.
- R5: In the wrapping modes (`mode` 01 = 8 words, 10 = 16 words, 11 = 32 words), each step increments only the low 3, 4 or 5 address bits modulo the group size. The upper bits keep the values of the start address, so the pointer never leaves its aligned group or its 64-word block.
- R6: In the linear mode (`mode` 00), each step adds 1 to the full-width address, which wraps to 0 after the all-ones address.
- R7: For a setting of 2, `ready` rises at edge E(N). For a setting above 2, it rises at edge E(N-1). In both cases it then stays at 1 until the next start.
- R8: A start sampled while a burst is in progress cancels that burst. `ready` is 0 after that edge, and the wait restarts from the newly captured address, setting and mode.
- R9: From edge E0 until edge E(N), `word_addr` holds the captured start address. Outside a burst it does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_code | input | 3 | Latency code carried by the write |
| start | input | 1 | Burst start pulse |
| start_addr | input | AW | Word address of the first word of the burst |
| mode | input | 2 | Burst mode: 00 linear, 01/10/11 wrap in 8/16/32 words |
| word_addr | output | AW | Address of the current data word |
| ready | output | 1 | Ready/valid strobe for the data stream |

## Verification
The assertions take it that `start` is a single-cycle pulse whose address and mode are valid in that same cycle. They also take it that `cfg_code` is stable whenever `cfg_we` is high. The bench changes inputs only on falling clock edges and holds each start high for exactly one cycle, so both conditions always hold. Configuration writes are placed between bursts. A write never coincides with a start, which keeps the "applies to later bursts" rule unambiguous.

// File: rtl/burst_lat_pkg.sv
package burst_lat_pkg;

    typedef enum logic [1:0] {
        MODE_LINEAR = 2'b00,
        MODE_WRAP8  = 2'b01,
        MODE_WRAP16 = 2'b10,
        MODE_WRAP32 = 2'b11
    } burst_mode_e;

    localparam int DEFAULT_CYCLES  = 7;
    localparam int MIN_CYCLES      = 2;
    localparam int LAST_VALID_CODE = 5;
    localparam int EDGE_PENALTY    = 2;
    localparam logic [5:0] EDGE_LOW_START = 6'h3E;

endpackage

// File: rtl/burst_lat_cfg.sv
module burst_lat_cfg
    import burst_lat_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_code,
    output logic [CW-1:0] setting
);

    typedef struct packed {
        logic [CW-1:0] cyc;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (cfg_code <= 3'(LAST_VALID_CODE))) begin
            st_d.cyc = CW'(cfg_code) + CW'(MIN_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cyc <= CW'(DEFAULT_CYCLES);
        end else begin
            st_q <= st_d;
        end
    end

    assign setting = st_q.cyc;

    AST_SETTING_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (setting >= CW'(MIN_CYCLES)) && (setting <= CW'(DEFAULT_CYCLES))); // R1

    AST_RESERVED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_code > 3'(LAST_VALID_CODE)) |=> $stable(setting)); // R2

endmodule

// File: rtl/burst_lat_timer.sv
module burst_lat_timer
    import burst_lat_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] base_cyc,
    input  logic          near_edge,
    output logic          ready,
    output logic          advance
);

    typedef struct packed {
        logic          act;
        logic          early;
        logic [CW-1:0] cnt;
        logic [CW-1:0] tot;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.act   = 1'b1;
            st_d.early = (base_cyc > CW'(MIN_CYCLES));
            st_d.cnt   = '0;
            st_d.tot   = base_cyc + (near_edge ? CW'(EDGE_PENALTY) : CW'(0));
        end else if (st_q.act && (st_q.cnt != st_q.tot)) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready   = st_q.act && (st_q.cnt >= (st_q.tot - CW'(st_q.early)));
    assign advance = st_q.act && (st_q.cnt == st_q.tot);

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ready); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready); // R8

    AST_READY_BEFORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !start) |-> ready); // R7

endmodule

// File: rtl/burst_lat_addr.sv
module burst_lat_addr
    import burst_lat_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [1:0]    mode,
    input  logic          advance,
    output logic [AW-1:0] word_addr
);

    typedef struct packed {
        logic [AW-1:0] addr;
        burst_mode_e   mode;
    } adr_state_t;

    adr_state_t st_d, st_q;

    function automatic logic [AW-1:0] group_mask(burst_mode_e m);
        case (m)
            MODE_WRAP8:  return AW'(7);
            MODE_WRAP16: return AW'(15);
            MODE_WRAP32: return AW'(31);
            default:     return '1;
        endcase
    endfunction

    logic [AW-1:0] mask;
    logic [AW-1:0] stepped;

    always_comb begin
        mask    = group_mask(st_q.mode);
        stepped = (st_q.addr & ~mask) | ((st_q.addr + AW'(1)) & mask);
        st_d    = st_q;
        if (start) begin
            st_d.addr = start_addr;
            st_d.mode = burst_mode_e'(mode);
        end else if (advance) begin
            st_d.addr = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= '0;
            st_q.mode <= MODE_LINEAR;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_addr = st_q.addr;

    AST_WRAP_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !start && st_q.mode != MODE_LINEAR)
        |=> (word_addr[AW-1:6] == $past(word_addr[AW-1:6]))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !start) |=> $stable(word_addr)); // R9

endmodule

// File: rtl/burst_lat_ctrl.sv
module burst_lat_ctrl
    import burst_lat_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_code,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [1:0]    mode,
    output logic [AW-1:0] word_addr,
    output logic          ready
);

    logic [CW-1:0] setting;
    logic          near_edge;
    logic          advance;

    assign near_edge = (start_addr[5:0] >= EDGE_LOW_START);

    burst_lat_cfg #(.CW(CW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_code (cfg_code),
        .setting  (setting)
    );

    burst_lat_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_cyc  (setting),
        .near_edge (near_edge),
        .ready     (ready),
        .advance   (advance)
    );

    burst_lat_addr #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .mode       (mode),
        .advance    (advance),
        .word_addr  (word_addr)
    );

    AST_READY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !start); // R7

endmodule

// File: tb/burst_lat_ctrl_test.sv
module burst_lat_ctrl_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_code = '0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [1:0]    mode = '0;
    logic [AW-1:0] word_addr;
    logic          ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    burst_lat_ctrl #(.AW(AW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_code   (cfg_code),
        .start      (start),
        .start_addr (start_addr),
        .mode       (mode),
        .word_addr  (word_addr),
        .ready      (ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_addr(input int sa, input int md, input int j);
        int m;
        case (md)
            1: m = 7;
            2: m = 15;
            3: m = 31;
            default: m = (1 << AW) - 1;
        endcase
        return (sa & ~m & ((1 << AW) - 1)) | ((sa + j) & m);
    endfunction

    task automatic write_cfg(input int code);
        cfg_we   = 1'b1;
        cfg_code = 3'(code);
        @(negedge clk);
        cfg_we   = 1'b0;
        @(negedge clk);
    endtask

    // called at a negedge; returns at a negedge after the last sample
    task automatic burst(input string req, input int sa, input int md,
                         input int setv, input int samples);
        int n;
        int early;
        n     = setv + (((sa & 63) >= 62) ? 2 : 0);
        early = (setv > 2) ? 1 : 0;
        start      = 1'b1;
        start_addr = AW'(sa);
        mode       = 2'(md);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < samples; k++) begin
            chk(req, int'(ready), (k >= n - early) ? 1 : 0);
            chk(req, int'(word_addr), (k < n) ? sa : exp_addr(sa, md, k - n));
            if (k < samples - 1) @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R8 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int addrs[7];
        addrs = '{16'h1200, 16'h1205, 16'h123D, 16'h123E, 16'h123F, 16'h12FE, 16'hFFFF};
        repeat (3) @(negedge clk);
        // R3: reset state
        chk("R3 reset ready", int'(ready), 0);
        chk("R3 reset addr", int'(word_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle addr", int'(word_addr), 0);
        // R3: default setting 7
        burst("R3 default", 16'h0040, 0, 7, 20);

        // R1 R4 R5 R6 R7 R9: sweep codes, addresses, modes
        for (int c = 0; c < 6; c++) begin
            write_cfg(c);
            for (int a = 0; a < 7; a++) begin
                for (int md = 0; md < 4; md++) begin
                    burst(md == 0 ? "R1 R4 R6 R7 R9 linear" : "R1 R4 R5 R7 R9 wrap",
                          addrs[a], md, c + 2, c + 2 + 2 + 40);
                end
            end
        end

        // R2: reserved codes ignored
        write_cfg(3);
        write_cfg(6);
        burst("R2 code6 ignored", 16'h0100, 1, 5, 16);
        write_cfg(7);
        burst("R2 code7 ignored", 16'h013E, 2, 5, 16);

        // R8: abort during latency and during data
        write_cfg(4);
        burst("R8 first partial", 16'h0200, 0, 6, 3);
        burst("R8 restart after latency abort", 16'h0333, 3, 6, 20);
        burst("R8 first into data", 16'h0400, 1, 6, 10);
        burst("R8 restart after data abort", 16'h053F, 2, 6, 24);

        // R3: reset returns the setting to default
        write_cfg(0);
        burst("R7 setting2 ready with data", 16'h0600, 0, 2, 8);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R3 reset ready again", int'(ready), 0);
        chk("R3 reset addr again", int'(word_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        burst("R3 default after reset", 16'h0700, 3, 7, 20);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule